// File: doc/BRIEF.md
# Incremental step program-verify sequencer

This controller drives one resistive memory cell through Form, Set or Reset by applying a train of voltage pulses whose amplitude climbs by a fixed step. After each pulse it runs a verify read and compares the digitized cell current with a target. It stops as soon as the target is met, or when the next pulse would climb past the ceiling of the operation's voltage window.

The analog drivers take unsigned voltage codes in 10 mV units for the bitline, the source line and the wordline. A pulse strobe and a read strobe frame the program and read phases. The cell current arrives as an unsigned code with 0.5 uA per LSB. Every phase duration is a parameter in clock cycles and is timed by one down-counter. With a 100 MHz clock the defaults give 1 us edges, a 10 us pulse plateau and a 10 us read.

When the sequence ends, the block raises done together with a fail flag, the last applied amplitude and the number of pulses. These stay valid until the next accepted start.

Top module: `stepver_seq`

## Requirements
- R1: After reset every voltage code is 0, both strobes are low, and busy, done and fail are 0.
- R2: Set (op code 1) drives pulses on the bitline only, with the wordline at code 140. The first pulse is at code 20 and each later pulse adds a step of 5 << step_sel (step_sel 0..3 gives 5, 10, 20 or 40). The ceiling is 350.
- R3: Reset (op code 2) drives pulses on the source line only, with the wordline at code 270. It uses the same start code, step encoding and ceiling as Set.
- R4: Form (op code 0) drives pulses on the bitline with the wordline at 140, from code 200 to a ceiling of 500 in steps of 1. step_sel has no effect.
- R5: Each pulse holds pulse_en high for 2*T_EDGE+T_PULSE cycles. Each verify read holds read_en high for T_READ cycles with the bitline at 20, the wordline at 140 and the source line at 0.
- R6: Set and Form pass when the sampled current code is 36 or more. Reset passes when it is 12 or less.
- R7: If the target is missed and the amplitude plus the step would exceed the ceiling, the run ends with done=1 and fail=1.
- R8: In the cycle after every pulse, all three voltage codes are 0 and both strobes are low.
- R9: A start while busy is ignored, and so is a start with op code 3.
- R10: When a run ends, done, fail, last_amp and pulse_cnt report its result and keep their values until the next accepted start. This holds for both pass and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command, sampled while idle |
| op | input | 2 | 0 Form, 1 Set, 2 Reset, 3 none |
| step_sel | input | 2 | Set/Reset step select, step = 5 << step_sel codes |
| cell_current | input | CW | Digitized verify current, 0.5 uA per LSB |
| bl_code | output | VW | Bitline voltage code, 10 mV per LSB |
| sl_code | output | VW | Source line voltage code |
| wl_code | output | VW | Wordline voltage code |
| pulse_en | output | 1 | Program pulse strobe |
| read_en | output | 1 | Verify read strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run finished, held |
| fail | output | 1 | Last run hit the ceiling without meeting the target |
| last_amp | output | VW | Amplitude of the last applied pulse |
| pulse_cnt | output | NW | Number of pulses in the last run |

## Verification
The bench builds the block with T_EDGE=2, T_PULSE=3 and T_READ=2. At these values a full 301-pulse Form sweep to the 500 ceiling, and 67-pulse Set sweeps at the smallest step, finish in a few thousand cycles. The voltage windows, thresholds and widths stay at their default values. This makes the exact ceiling landings reachable: the 0.05 V step lands on 350, and the 0.4 V step stops at 340. The current codes exactly at 36 and 12, and one past each, can also be exercised within the run budget.

// File: rtl/stepver_pkg.sv
package stepver_pkg;
    // Operation select carried on the op port
    typedef enum logic [1:0] {
        OP_FORM  = 2'd0,
        OP_SET   = 2'd1,
        OP_RESET = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE, PH_RISE, PH_HOLD, PH_FALL, PH_GAP, PH_READ, PH_EVAL
    } phase_e;
endpackage

// File: rtl/stepver_timer.sv
// Phase timer: a down-counter loaded on phase entry with (duration - 1).
// Assumes every loaded value fits in TW bits; zero marks the last cycle.
module stepver_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/stepver_amp.sv
// Amplitude register: loaded with the window start, advanced by one step.
// over flags that one more step would exceed the ceiling (one extra bit, no wrap).
module stepver_amp #(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    input  logic          adv,
    input  logic [VW-1:0] step,
    input  logic [VW-1:0] ceil,
    output logic [VW-1:0] amp,
    output logic          over
);
    // Hold the present pulse amplitude
    always_ff @(posedge clk) begin
        if (!rst_n)     amp <= '0;
        else if (load)  amp <= load_val;
        else if (adv)   amp <= amp + step;
    end

    // Ceiling look-ahead for the next pulse
    always_comb begin
        over = ({1'b0, amp} + {1'b0, step}) > {1'b0, ceil};
    end
endmodule

// File: rtl/stepver_verify.sv
// Verify comparator: captures pass/miss of the read current on the last read cycle.
// below_mode selects the "at or below lo" rule, otherwise "at or above hi".
module stepver_verify #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic          below_mode,
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] hi_thr,
    input  logic [CW-1:0] lo_thr,
    output logic          hit
);
    // Register the comparison result for the evaluate phase
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hit <= 1'b0;
        else if (sample)     hit <= below_mode ? (cur <= lo_thr) : (cur >= hi_thr);
    end
endmodule

// File: rtl/stepver_seq.sv
// Incremental step program-verify sequencer (top).
// Runs pulse -> gap -> verify read -> evaluate loops until the current target
// is met or the ceiling is reached. Assumes T_EDGE, T_PULSE, T_READ >= 1.
module stepver_seq
    import stepver_pkg::*;
#(
    parameter int VW           = 10,
    parameter int CW           = 8,
    parameter int NW           = 10,
    parameter int T_EDGE       = 100,
    parameter int T_PULSE      = 1000,
    parameter int T_READ       = 1000,
    parameter int V_SR_START   = 20,
    parameter int V_SR_CEIL    = 350,
    parameter int V_FM_START   = 200,
    parameter int V_FM_CEIL    = 500,
    parameter int V_FM_STEP    = 1,
    parameter int V_BASE_STEP  = 5,
    parameter int V_WL_NORM    = 140,
    parameter int V_WL_RESET   = 270,
    parameter int V_READ       = 20,
    parameter int I_HI_MIN     = 36,
    parameter int I_LO_MAX     = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [1:0]    step_sel,
    input  logic [CW-1:0] cell_current,
    output logic [VW-1:0] bl_code,
    output logic [VW-1:0] sl_code,
    output logic [VW-1:0] wl_code,
    output logic          pulse_en,
    output logic          read_en,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [VW-1:0] last_amp,
    output logic [NW-1:0] pulse_cnt
);
    localparam int TMAX = (T_PULSE > T_READ) ? ((T_PULSE > T_EDGE) ? T_PULSE : T_EDGE)
                                             : ((T_READ > T_EDGE) ? T_READ : T_EDGE);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PLEN = 2 * T_EDGE + T_PULSE;

    phase_e        phase, nxt_phase;
    op_e           op_q;
    logic [VW-1:0] step_q, ceil_v, amp;
    logic          tmr_load, tmr_zero, amp_load, amp_adv, amp_over, vfy_sample, hit;
    logic [TW-1:0] tmr_val;
    logic          accept;

    assign accept = (phase == PH_IDLE) && start && (op_e'(op) != OP_NONE);
    assign ceil_v = (op_q == OP_FORM) ? VW'(V_FM_CEIL) : VW'(V_SR_CEIL);

    stepver_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    stepver_amp #(.VW(VW)) u_amp (
        .clk(clk), .rst_n(rst_n), .load(amp_load),
        .load_val((op_e'(op) == OP_FORM) ? VW'(V_FM_START) : VW'(V_SR_START)),
        .adv(amp_adv), .step(step_q), .ceil(ceil_v), .amp(amp), .over(amp_over)
    );

    stepver_verify #(.CW(CW)) u_vfy (
        .clk(clk), .rst_n(rst_n), .clear(accept), .sample(vfy_sample),
        .below_mode(op_q == OP_RESET), .cur(cell_current),
        .hi_thr(CW'(I_HI_MIN)), .lo_thr(CW'(I_LO_MAX)), .hit(hit)
    );

    // Next-phase decode and per-phase timer loads
    always_comb begin
        nxt_phase  = phase;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        amp_load   = 1'b0;
        amp_adv    = 1'b0;
        vfy_sample = 1'b0;
        unique case (phase)
            PH_IDLE: if (accept) begin
                nxt_phase = PH_RISE; tmr_load = 1'b1; tmr_val = TW'(T_EDGE - 1); amp_load = 1'b1;
            end
            PH_RISE: if (tmr_zero) begin
                nxt_phase = PH_HOLD; tmr_load = 1'b1; tmr_val = TW'(T_PULSE - 1);
            end
            PH_HOLD: if (tmr_zero) begin
                nxt_phase = PH_FALL; tmr_load = 1'b1; tmr_val = TW'(T_EDGE - 1);
            end
            PH_FALL: if (tmr_zero) begin
                nxt_phase = PH_GAP; tmr_load = 1'b1;
            end
            PH_GAP: begin
                nxt_phase = PH_READ; tmr_load = 1'b1; tmr_val = TW'(T_READ - 1);
            end
            PH_READ: if (tmr_zero) begin
                vfy_sample = 1'b1; nxt_phase = PH_EVAL; tmr_load = 1'b1;
            end
            PH_EVAL: begin
                if (hit || amp_over) nxt_phase = PH_IDLE;
                else begin
                    nxt_phase = PH_RISE; tmr_load = 1'b1; tmr_val = TW'(T_EDGE - 1); amp_adv = 1'b1;
                end
            end
            default: nxt_phase = PH_IDLE;
        endcase
    end

    // Phase register, run set-up and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; op_q <= OP_SET; step_q <= '0;
            pulse_cnt <= '0; done <= 1'b0; fail <= 1'b0;
        end else begin
            phase <= nxt_phase;
            if (accept) begin
                op_q      <= op_e'(op);
                step_q    <= (op_e'(op) == OP_FORM) ? VW'(V_FM_STEP) : (VW'(V_BASE_STEP) << step_sel);
                pulse_cnt <= NW'(1);
                done      <= 1'b0;
                fail      <= 1'b0;
            end else if (phase == PH_EVAL) begin
                if (hit)           done <= 1'b1;
                else if (amp_over) begin done <= 1'b1; fail <= 1'b1; end
                else               pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    // Analog code decode; zero outside the pulse and read phases
    always_comb begin
        bl_code  = '0;
        sl_code  = '0;
        wl_code  = '0;
        pulse_en = 1'b0;
        read_en  = 1'b0;
        if (phase == PH_RISE || phase == PH_HOLD || phase == PH_FALL) begin
            pulse_en = 1'b1;
            wl_code  = (op_q == OP_RESET) ? VW'(V_WL_RESET) : VW'(V_WL_NORM);
            if (op_q == OP_RESET) sl_code = amp;
            else                  bl_code = amp;
        end else if (phase == PH_READ) begin
            read_en = 1'b1;
            wl_code = VW'(V_WL_NORM);
            bl_code = VW'(V_READ);
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign last_amp = amp;

    // Pulse length monitor counter for the assertion below
    logic [TW+2:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (pulse_en) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_en) |-> (run_q == (TW+3)'(PLEN)));
    // R8
    phase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_en) |-> (!read_en && bl_code == '0 && sl_code == '0 && wl_code == '0));
    // R7
    amp_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |-> (amp <= ceil_v));
    // R2
    amp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && $past(phase) == PH_EVAL) |-> (amp == $past(amp) + $past(step_q)));
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));
endmodule

// File: tb/stepver_seq_test.sv
module stepver_seq_test;
    localparam int VW = 10, CW = 8, NW = 10;
    localparam int TE = 2, TP = 3, TR = 2;
    localparam int PLEN = 2 * TE + TP;

    typedef struct {
        int op; int step; int first; int amp; int cnt; bit fl;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] op = 2'd0, step_sel = 2'd0;
    logic [CW-1:0] cell_current;
    logic [VW-1:0] bl_code, sl_code, wl_code, last_amp;
    logic [NW-1:0] pulse_cnt;
    logic pulse_en, read_en, busy, done, fail;

    always #4 clk = ~clk;

    stepver_seq #(.VW(VW), .CW(CW), .NW(NW), .T_EDGE(TE), .T_PULSE(TP), .T_READ(TR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .step_sel(step_sel),
        .cell_current(cell_current), .bl_code(bl_code), .sl_code(sl_code), .wl_code(wl_code),
        .pulse_en(pulse_en), .read_en(read_en), .busy(busy), .done(done), .fail(fail),
        .last_amp(last_amp), .pulse_cnt(pulse_cnt)
    );

    // Behavioural cell: switches once a pulse reaches the threshold code
    logic sw = 1'b0, mode_rst = 1'b0;
    int thr = 1023, hi_v = 48, lo_v = 4;
    assign cell_current = CW'(mode_rst ? (sw ? lo_v : hi_v) : (sw ? hi_v : lo_v));
    always @(negedge clk)
        if (pulse_en && (int'(mode_rst ? sl_code : bl_code) >= thr)) sw <= 1'b1;

    int n_chk = 0, n_fail = 0;
    item_t sb[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic item_t predict(input int o, input int s, input int t, input int h, input int l);
        item_t it;
        int ceil, a, n;
        bit can;
        it.op   = o;
        it.step = (o == 0) ? 1 : (5 << s);
        it.first = (o == 0) ? 200 : 20;
        ceil = (o == 0) ? 500 : 350;
        can  = (o == 2) ? (l <= 12) : (h >= 36);
        a = it.first; n = 1;
        while (1) begin
            if (can && a >= t) begin it.fl = 1'b0; break; end
            if (a + it.step > ceil) begin it.fl = 1'b1; break; end
            a += it.step; n++;
        end
        it.amp = a; it.cnt = n;
        return it;
    endfunction

    // Monitor: phase checks every cycle, scoreboard compare at each completion
    bit prev_pe = 0, prev_rd = 0, prev_done = 0, have_amp = 0;
    int run = 0, rrun = 0, prev_amp = 0, first_amp = 0;
    int e_line = 0, e_len = 0, e_read = 0, e_gap = 0, e_step = 0;
    always @(negedge clk) begin
        if (pulse_en && sb.size() > 0) begin
            int lv;
            lv = (sb[0].op == 2) ? int'(sl_code) : int'(bl_code);
            run++;
            if (sb[0].op == 2) begin
                if (bl_code != 0 || wl_code != 270) e_line++;
            end else begin
                if (sl_code != 0 || wl_code != 140) e_line++;
            end
            if (!prev_pe) begin
                if (have_amp && lv != prev_amp + sb[0].step) e_step++;
                if (!have_amp) first_amp = lv;
                have_amp = 1; prev_amp = lv;
            end
        end else if (prev_pe) begin
            if (run != PLEN) e_len++;
            run = 0;
            if (bl_code != 0 || sl_code != 0 || wl_code != 0 || read_en) e_gap++;
        end
        if (read_en) begin
            rrun++;
            if (bl_code != 20 || sl_code != 0 || wl_code != 140) e_read++;
        end else if (prev_rd) begin
            if (rrun != TR) e_read++;
            rrun = 0;
        end
        if (done && !prev_done && sb.size() > 0) begin
            item_t it;
            string lr;
            it = sb.pop_front();
            lr = (it.op == 0) ? "R4" : (it.op == 1) ? "R2" : "R3";
            chk(fail == it.fl, it.fl ? "R7" : "R6", "fail flag", int'(fail), int'(it.fl));
            chk(int'(last_amp) == it.amp, "R10", "last amplitude", int'(last_amp), it.amp);
            chk(int'(pulse_cnt) == it.cnt, "R10", "pulse count", int'(pulse_cnt), it.cnt);
            chk(first_amp == it.first, lr, "first amplitude", first_amp, it.first);
            chk(e_line == 0, lr, "line/wordline errors", e_line, 0);
            chk(e_step == 0, lr, "step errors", e_step, 0);
            chk(e_len == 0, "R5", "pulse length errors", e_len, 0);
            chk(e_read == 0, "R5", "read phase errors", e_read, 0);
            chk(e_gap == 0, "R8", "gap errors", e_gap, 0);
            e_line = 0; e_len = 0; e_read = 0; e_gap = 0; e_step = 0; have_amp = 0;
        end
        prev_pe = pulse_en; prev_rd = read_en; prev_done = done;
    end

    // Driver: push the expected result, then launch the run
    task automatic run_op(input int o, input int s, input int t, input int h, input int l, input bit poke);
        @(negedge clk);
        sw = 1'b0; thr = t; hi_v = h; lo_v = l; mode_rst = (o == 2);
        sb.push_back(predict(o, s, t, h, l));
        op = 2'(o); step_sel = 2'(s); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            op = 2'd2; step_sel = 2'd0; start = 1'b1;   // R9: ignored while busy
            @(negedge clk); start = 1'b0; op = 2'(o);
        end
        @(posedge done);
        repeat (2) @(negedge clk);
    endtask

    bit finished = 0;
    initial begin
        repeat (3) @(negedge clk);
        chk(bl_code == 0 && sl_code == 0 && wl_code == 0, "R1", "codes in reset", int'(bl_code | sl_code | wl_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pulse_en && !read_en && !busy && !done && !fail, "R1", "flags after reset",
            int'({pulse_en, read_en, busy, done, fail}), 0);

        run_op(1, 1, 85, 48, 4, 0);     // R2 Set, 0.1 V step
        run_op(1, 3, 100, 48, 4, 0);    // R2 Set, 0.4 V step
        run_op(1, 0, 350, 36, 4, 0);    // R6 boundary 36, lands on 350
        run_op(1, 3, 1023, 48, 4, 0);   // R7 ceiling at 340
        run_op(1, 2, 20, 35, 4, 0);     // R6 current 35 never passes
        run_op(2, 2, 150, 40, 12, 0);   // R3 Reset, boundary 12
        run_op(2, 3, 20, 40, 13, 0);    // R6 current 13 never passes
        run_op(0, 3, 250, 48, 4, 0);    // R4 Form, step_sel ignored
        run_op(0, 1, 1023, 48, 4, 0);   // R4 full sweep to 500 and fail
        run_op(1, 1, 85, 48, 4, 1);     // R9 start while busy

        // R9: op code 3 is not accepted; R10: result held
        @(negedge clk); op = 2'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy, "R9", "busy after op 3", int'(busy), 0);
        chk(done, "R10", "done held", int'(done), 1);
        chk(int'(last_amp) == 90, "R10", "amplitude held", int'(last_amp), 90);
        chk(int'(pulse_cnt) == 8, "R10", "count held", int'(pulse_cnt), 8);
        chk(sb.size() == 0, "R10", "pending results", sb.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule